// File: doc/BRIEF.md
# FFT Pass Scaling Controller

This block sits beside a radix-2 FFT core that runs five passes per transform and can halve all data on any pass when asked. It watches the core's busy flag, its pass number and its overflow flag. From these it decides, pass by pass, whether to ask for a one-bit right shift. It also gives a verdict on every finished transform.

Two modes are available. In fixed mode the shift pattern comes from a loadable 5-bit register, and any overflow marks the frame as an error. In adaptive mode the controller starts with no shifts. Each time a pass overflows, it adds that pass to a sticky mask, and every frame with an overflow is reported as invalid. Over a few frames the mask settles on the smallest set of shifted passes that keeps a steady signal free of overflow. From then on, frames are reported valid.

The core latches the shift request when a pass starts. For this reason the request always shows the bit for the pass that comes next, not the pass that is running.

Top module: `fft_scale_ctrl`

## Requirements
- R1: A synchronous reset loads the fixed pattern with its default and clears the adaptive mask. It also clears `frame_done`, `frame_valid` and `frame_err`.
- R2: `shift_req` shows bit k of the active pattern, where k is the upcoming pass. While `core_busy` is low, k = 0. While pass p (0 to 3) runs, k = p+1. While pass 4 runs, k = 0.
- R3: The default fixed pattern is 5'b10101, with bit i belonging to pass i, so the even passes 0, 2 and 4 are shifted.
- R4: When `pat_wr` is high at a clock edge, `pat_din` becomes the fixed pattern from the next cycle on.
- R5: `core_ovf` counts only on the last cycle of a pass, meaning the cycle before `core_pass` changes or before `core_busy` falls. A high level on any other cycle has no effect.
- R6: `frame_done` is high for exactly one cycle: the second cycle in which `core_busy` is low after a frame.
- R7: `frame_valid` is high together with `frame_done` only if none of the five passes had an overflow that counted.
- R8: `frame_err` is high together with `frame_done` only in fixed mode, and only when some pass had an overflow that counted. In adaptive mode it stays low.
- R9: In adaptive mode the mask starts at zero. An overflow that counts in pass p sets mask bit p. Nothing but reset clears a mask bit.
- R10: In fixed mode, overflows leave the adaptive mask unchanged. `mode` (0 = fixed, 1 = adaptive) chooses which pattern drives `shift_req`.
- R11: A reset asserted in the middle of a frame drops that frame. After it, the adaptive mask is zero and the fixed pattern is back at its default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = fixed pattern, 1 = adaptive mask |
| pat_wr | input | 1 | Load strobe for the fixed pattern |
| pat_din | input | 5 | New fixed pattern, bit i for pass i |
| core_busy | input | 1 | Core is running a transform |
| core_pass | input | 3 | Pass number of the core, 0 to 4 |
| core_ovf | input | 1 | Overflow flag of the current pass |
| shift_req | output | 1 | Right-shift request for the upcoming pass |
| frame_done | output | 1 | One-cycle pulse when a frame verdict is ready |
| frame_valid | output | 1 | Frame had no overflow (qualified by frame_done) |
| frame_err | output | 1 | Fixed-mode overflow error (qualified by frame_done) |

## Verification
Two things happen in the same cycle when the last pass ends with an overflow. The sample from pass 4 must both set mask bit 4 and change the frame verdict, and the frame closes at that moment too. The bench forces this case: it raises `core_ovf` on the final busy cycle of pass 4. It then checks that the frame comes out invalid, and that bit 4 shows up on `shift_req` during pass 3 of the next frame. Another collision is a pattern write on the last cycle of a pass, which lands on the same edge that moves the core to the next pass. For both collisions, a cycle-by-cycle reference model gives the expected output on every clock.

// File: rtl/fft_scale_ctrl.sv
module fft_scale_ctrl #(
  parameter int PASSES = 5,
  parameter int PW = 3,
  parameter logic [PASSES-1:0] FIXED_INIT = PASSES'('b10101)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              pat_wr,
  input  logic [PASSES-1:0] pat_din,
  input  logic              core_busy,
  input  logic [PW-1:0]     core_pass,
  input  logic              core_ovf,
  output logic              shift_req,
  output logic              frame_done,
  output logic              frame_valid,
  output logic              frame_err
);
  localparam logic [PW-1:0] LAST = PW'(PASSES - 1);

  logic [PASSES-1:0] fixed_pat, adapt_mask;
  logic              busy_q, ovf_q, bad_q;
  logic [PW-1:0]     pass_q, tgt;
  logic              done_q, valid_q, err_q;

  wire pass_end  = busy_q && (!core_busy || core_pass != pass_q);
  wire frame_end = busy_q && !core_busy;
  wire hit       = pass_end && ovf_q;
  wire [PASSES-1:0] active = mode ? adapt_mask : fixed_pat;

  always_comb begin
    if (!core_busy || core_pass >= LAST) tgt = '0;
    else tgt = core_pass + 1'b1;
  end

  assign shift_req   = active[tgt];
  assign frame_done  = done_q;
  assign frame_valid = valid_q;
  assign frame_err   = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fixed_pat  <= FIXED_INIT;
      adapt_mask <= '0;
      busy_q     <= 1'b0;
      pass_q     <= '0;
      ovf_q      <= 1'b0;
      bad_q      <= 1'b0;
      done_q     <= 1'b0;
      valid_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      busy_q  <= core_busy;
      pass_q  <= core_pass;
      ovf_q   <= core_ovf;
      if (pat_wr) fixed_pat <= pat_din;
      if (hit && mode && pass_q <= LAST) adapt_mask[pass_q] <= 1'b1;
      if (frame_end) bad_q <= 1'b0;
      else if (hit)  bad_q <= 1'b1;
      done_q  <= frame_end;
      valid_q <= frame_end && !(bad_q || hit);
      err_q   <= frame_end && !mode && (bad_q || hit);
    end
  end
endmodule

// File: rtl/fft_scale_ctrl_chk.sv
module fft_scale_ctrl_chk #(
  parameter int PASSES = 5,
  parameter int PW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mode,
  input logic              core_busy,
  input logic [PW-1:0]     core_pass,
  input logic              frame_done,
  input logic              frame_valid,
  input logic              frame_err,
  input logic [PASSES-1:0] adapt_mask
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_err_invalid_R8: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> (frame_done && !frame_valid));

  assert_no_adapt_err_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !(frame_err && $past(mode)));

  assert_mask_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(adapt_mask) & ~adapt_mask) == '0));

  assert_mid_pass_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && core_busy && $past(core_busy) && core_pass == $past(core_pass))
      |=> $stable(adapt_mask));

  assert_fixed_keeps_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !mode) |=> $stable(adapt_mask));
endmodule

bind fft_scale_ctrl fft_scale_ctrl_chk #(.PASSES(PASSES), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .core_busy(core_busy),
  .core_pass(core_pass), .frame_done(frame_done), .frame_valid(frame_valid),
  .frame_err(frame_err), .adapt_mask(adapt_mask)
);

// File: tb/fft_scale_ctrl_tb.sv
`timescale 1ns/1ps
module fft_scale_ctrl_tb;
  logic clk = 0, rst = 1, mode = 0, pat_wr = 0, core_busy = 0, core_ovf = 0;
  logic [4:0] pat_din = 0;
  logic [2:0] core_pass = 0;
  logic shift_req, frame_done, frame_valid, frame_err;
  int total = 0, bad = 0;
  bit live = 0;

  always #2 clk = ~clk;

  fft_scale_ctrl u_dut (
    .clk(clk), .rst(rst), .mode(mode), .pat_wr(pat_wr), .pat_din(pat_din),
    .core_busy(core_busy), .core_pass(core_pass), .core_ovf(core_ovf),
    .shift_req(shift_req), .frame_done(frame_done),
    .frame_valid(frame_valid), .frame_err(frame_err));

  // behavioural reference
  int m_fix[5], m_msk[5];
  int m_lb, m_lp, m_lo, m_bad;
  bit e_done, e_valid, e_err;

  always @(posedge clk) begin
    if (rst) begin
      m_fix = '{1, 0, 1, 0, 1};
      m_msk = '{0, 0, 0, 0, 0};
      m_lb = 0; m_lp = 0; m_lo = 0; m_bad = 0;
      e_done = 0; e_valid = 0; e_err = 0;
    end else begin
      int pe, fe, h;
      pe = m_lb && (!core_busy || int'(core_pass) != m_lp);
      fe = m_lb && !core_busy;
      h  = pe && m_lo;
      e_done  = fe != 0;
      e_valid = fe && !(m_bad || h);
      e_err   = fe && !mode && (m_bad || h);
      if (h && mode && m_lp < 5) m_msk[m_lp] = 1;
      if (pat_wr) for (int i = 0; i < 5; i++) m_fix[i] = pat_din[i];
      if (fe) m_bad = 0; else if (h) m_bad = 1;
      m_lb = core_busy; m_lp = core_pass; m_lo = core_ovf;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk5(string tag, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (live && !rst) begin
      int k, e;
      k = (!core_busy || core_pass >= 4) ? 0 : int'(core_pass) + 1;
      e = mode ? m_msk[k] : m_fix[k];
      chk("R2 shift_req model", shift_req, e[0]);
      chk("R6 frame_done model", frame_done, e_done);
      chk("R7 frame_valid model", frame_valid, e_valid);
      chk("R8 frame_err model", frame_err, e_err);
    end
  end

  logic [4:0] sh;
  logic fd, fv, fe_o;

  task automatic run_frame(int len, logic [4:0] ov_last, logic [4:0] ov_mid,
                           int wr_pass, logic [4:0] wr_val);
    for (int p = 0; p < 5; p++) begin
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        core_busy = 1; core_pass = 3'(p);
        core_ovf = (c == len-1 && ov_last[p]) || (c == len/2 && c != len-1 && ov_mid[p]);
        pat_wr = (p == wr_pass && c == len-1);
        pat_din = wr_val;
        #1;
        if (c == 0) sh[p] = shift_req;
      end
    end
    @(negedge clk);
    core_busy = 0; core_pass = 0; core_ovf = 0; pat_wr = 0;
    @(negedge clk); #1;
    fd = frame_done; fv = frame_valid; fe_o = frame_err;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; live = 1;
    #1;
    chk("R1 done after reset", frame_done, 0);
    chk("R3 default bit0 idle", shift_req, 1);

    run_frame(4, 0, 0, -1, 0);
    chk5("R3 default pattern per pass", sh, 5'b11010);
    chk("R7 clean fixed valid", fv, 1);
    chk("R8 clean fixed no err", fe_o, 0);
    chk("R6 done pulse", fd, 1);

    run_frame(3, 5'b01000, 0, -1, 0);
    chk("R8 fixed overflow err", fe_o, 1);
    chk("R7 fixed overflow invalid", fv, 0);

    run_frame(5, 0, 5'b11111, -1, 0);
    chk("R5 mid-pass overflow ignored valid", fv, 1);
    chk("R5 mid-pass overflow no err", fe_o, 0);

    @(negedge clk); pat_wr = 1; pat_din = 5'b00110;
    @(negedge clk); pat_wr = 0; #1;
    chk("R4 loaded bit0", shift_req, 0);
    run_frame(3, 0, 0, -1, 0);
    chk5("R4 loaded pattern", sh, 5'b00011);
    run_frame(3, 0, 0, 1, 5'b11111);
    chk5("R4 write at pass boundary", sh, 5'b11111);

    @(negedge clk); mode = 1; #1;
    chk("R9 mask starts zero", shift_req, 0);
    run_frame(4, 5'b01010, 0, -1, 0);
    chk("R9 adaptive overflow invalid", fv, 0);
    chk("R8 adaptive no err", fe_o, 0);
    run_frame(4, 0, 0, -1, 0);
    chk5("R9 mask learned", sh, 5'b00101);
    chk("R9 learned frame valid", fv, 1);

    run_frame(3, 5'b10010, 0, -1, 0);
    chk("R7 last-pass overflow invalid", fv, 0);
    #1;
    chk("R9 bit0 still clear", shift_req, 0);
    run_frame(3, 0, 0, -1, 0);
    chk5("R9 last-pass bit set", sh, 5'b01101);

    @(negedge clk); mode = 0;
    run_frame(3, 5'b00001, 0, -1, 0);
    chk("R8 fixed err pass0", fe_o, 1);
    @(negedge clk); mode = 1;
    run_frame(3, 0, 0, -1, 0);
    chk5("R10 mask untouched by fixed", sh, 5'b01101);

    @(negedge clk); core_busy = 1; core_pass = 0;
    @(negedge clk); core_pass = 1;
    @(negedge clk); core_pass = 2; core_ovf = 1;
    @(negedge clk); rst = 1; core_busy = 0; core_pass = 0; core_ovf = 0;
    @(negedge clk); rst = 0;
    run_frame(3, 0, 0, -1, 0);
    chk5("R11 mask cleared", sh, 5'b00000);
    chk("R11 frame valid after reset", fv, 1);
    @(negedge clk); mode = 0; #1;
    chk("R11 fixed default back", shift_req, 1);
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule